// File: doc/BRIEF.md
# Pipelined Ones-Complement Checksum Accumulator

This block sums a stream of 32-bit words into two separate 16-bit ones-complement partial sums, one for the lower half-word of each word and one for the upper. It sits beside a data mover and sees every word that crosses the bus while summing is enabled. Software or a later stage folds the two halves and inverts the result to obtain the final checksum; that step is not part of this block.

Each 16-bit half is a ring of six small carry-lookahead groups. A carry leaving a group is held in a one-bit register and enters the next group one clock later. The carry leaving the top group of a half re-enters at bit 0 of the same half, which provides the end-around carry of ones-complement arithmetic. Because no carry ripples across a whole half in one cycle, the logic depth per clock is that of a three-bit adder. The cost is that a result needs a few idle clocks to settle after the last word. A flag reports when the value is final.

A word presented with the add strobe is captured in an input register on one clock edge and accumulated on the next. A new word can be presented on every clock. When the strobe is low a zero is accumulated, so held carries keep draining.

Top module: `ocsum_ring_acc`

## Requirements
- R1: Bits 15..0 of `sum` accumulate only bits 15..0 of each word and bits 31..16 accumulate only bits 31..16; no carry passes between the halves.
- R2: Once settled, each half of `sum` equals the 16-bit end-around-carry sum of the matching half-words of all words added since the last clear or reset, starting from zero.
- R3: Each half is cut into groups of 3, 3, 2, 3, 3 and 2 bits from its bit 0 upward. A carry out of a group reaches the next group only on the following clock, and the top group's carry re-enters the half's bit 0. After 0x0000FFFF then 0x00000001 are added, the low half reads 0xFFF8 on the clock after the second word is accumulated.
- R4: When `add` is low in a cycle, the value on `din` has no effect on `sum`; held carries keep moving.
- R5: With `add` held low, all held carries are zero within 7 clocks of the last accumulating edge; for the R3 case `settled` rises exactly 6 clocks after that edge, with a final value of 0x00000001.
- R6: `settled` is 1 exactly when no carry is held and no captured word is waiting; while it is 1 and `clr` is low, `sum` holds its value.
- R7: `clr` high at a clock edge zeroes the sum, every carry register and the input register, and wins over `add` in the same cycle.
- R8: `rst_n` low at a clock edge has the same effect as `clr`; after it `sum` is 0 and `settled` is 1.
- R9: A word presented with `add` high at edge A changes `sum` no earlier than edge A+1, and a new word may be presented on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of sum, carries and input register |
| add | input | 1 | Accumulate the word on `din` |
| din | input | 32 | Data word |
| sum | output | 32 | Two 16-bit partial sums, upper and lower |
| settled | output | 1 | No carry held and no captured word waiting |

## Verification
The bench builds the block with its default of two halves and the six-group layout per half, so the full 32-bit bus and both independent rings are present. Sixteen-bit all-ones halves are reachable with a single word. This lets a carry be pushed around a whole ring, so the exact settle count and the end-around wrap can be observed. A 64-word stream with gaps is compared against an end-around-carry model, and short table cases cover overflow at each half boundary.

// File: rtl/ocsum_pkg.sv
// Shared layout constants for the ring checksum accumulator.
// Assumes every group is at least two bits wide, which bounds carry draining.
package ocsum_pkg;
    localparam int GRP_N = 6;
    localparam int GRP_W [GRP_N] = '{3, 3, 2, 3, 3, 2};

    // Lowest bit index of group g inside a half.
    function automatic int grp_lo(input int g);
        int s;
        s = 0;
        for (int i = 0; i < g; i++) s += GRP_W[i];
        return s;
    endfunction

    localparam int HALF_W    = grp_lo(GRP_N);
    localparam int DRAIN_MAX = GRP_N + 1;
endpackage

// File: rtl/ocsum_in_stage.sv
// Input register: captures the data word and the add strobe on every clock.
// Assumes clear and reset are synchronous and zero both fields.
module ocsum_in_stage #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          add,
    input  logic [DW-1:0] din,
    output logic          add_q,
    output logic [DW-1:0] word_q
);
    // Capture stage: hold one word and its strobe for the accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            add_q  <= 1'b0;
            word_q <= '0;
        end else begin
            add_q  <= add;
            word_q <= din;
        end
    end

    // R7: clear empties the input register
    p_latch_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!add_q && word_q == '0));
endmodule

// File: rtl/ocsum_la_group.sv
// One carry-lookahead group of a ones-complement ring: adds its slice of the
// addend plus a registered carry-in to its bits, registers the carry-out.
// Assumes the carry-in comes from the neighbouring group's carry register.
module ocsum_la_group #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         add_en,
    input  logic [W-1:0] addend,
    input  logic         cin,
    output logic [W-1:0] bits_q,
    output logic         cout_q
);
    logic [W-1:0] opnd;
    logic [W-1:0] prop;
    logic [W-1:0] gen;
    logic [W:0]   cch;

    // Lookahead terms: gate the addend, then form generate/propagate chain.
    always_comb begin
        opnd   = add_en ? addend : '0;
        prop   = bits_q ^ opnd;
        gen    = bits_q & opnd;
        cch[0] = cin;
        for (int i = 0; i < W; i++) cch[i+1] = gen[i] | (prop[i] & cch[i]);
    end

    // Group state: new sum bits and the carry held for the next group.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            bits_q <= '0;
            cout_q <= 1'b0;
        end else begin
            bits_q <= prop ^ cch[W-1:0];
            cout_q <= cch[W];
        end
    end

    // R4: with no data and no incoming carry a group cannot emit a carry
    p_idle_no_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!add_en && !cin) |=> !cout_q);
endmodule

// File: rtl/ocsum_half_ring.sv
// One 16-bit ones-complement partial sum built as a ring of lookahead groups
// whose carries are registered; the top carry wraps to bit 0.
// Assumes the group layout from ocsum_pkg covers the half exactly.
module ocsum_half_ring
    import ocsum_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              add_en,
    input  logic [HALF_W-1:0] addend,
    output logic [HALF_W-1:0] sum_q,
    output logic [GRP_N-1:0]  carries_q
);
    localparam int CW = $clog2(DRAIN_MAX + 1) + 1;

    for (genvar g = 0; g < GRP_N; g++) begin : g_grp
        localparam int LO   = grp_lo(g);
        localparam int W    = GRP_W[g];
        localparam int PREV = (g == 0) ? GRP_N - 1 : g - 1;
        ocsum_la_group #(.W(W)) u_grp (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clr),
            .add_en (add_en),
            .addend (addend[LO +: W]),
            .cin    (carries_q[PREV]),
            .bits_q (sum_q[LO +: W]),
            .cout_q (carries_q[g])
        );
    end

    logic [CW-1:0] idle_cnt;

    // Drain watch: clocks since the last accumulation while carries remain.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || add_en) begin
            idle_cnt <= '0;
        end else if ((|carries_q) && (idle_cnt != CW'(DRAIN_MAX))) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    // R5: carries drain within DRAIN_MAX idle clocks
    p_drain_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((|carries_q) && !add_en) |-> (idle_cnt < CW'(DRAIN_MAX)));

    // R7: clear zeroes this half and its carries
    p_half_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sum_q == '0 && carries_q == '0));
endmodule

// File: rtl/ocsum_ring_acc.sv
// Top: input register feeding one ring accumulator per half-word.
// Assumes the consumer folds and inverts the halves once settled is high.
module ocsum_ring_acc
    import ocsum_pkg::*;
#(
    parameter int NUM_HALVES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         add,
    input  logic [NUM_HALVES*HALF_W-1:0] din,
    output logic [NUM_HALVES*HALF_W-1:0] sum,
    output logic                         settled
);
    localparam int DW = NUM_HALVES * HALF_W;

    logic          add_q;
    logic [DW-1:0] word_q;
    logic [GRP_N-1:0] carr [NUM_HALVES];

    ocsum_in_stage #(.DW(DW)) u_in (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .add    (add),
        .din    (din),
        .add_q  (add_q),
        .word_q (word_q)
    );

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        ocsum_half_ring u_half (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (clr),
            .add_en    (add_q),
            .addend    (word_q[h*HALF_W +: HALF_W]),
            .sum_q     (sum[h*HALF_W +: HALF_W]),
            .carries_q (carr[h])
        );
    end

    // Settled flag: nothing pending in the input register or any carry.
    always_comb begin
        settled = !add_q;
        for (int h = 0; h < NUM_HALVES; h++) settled = settled && (carr[h] == '0);
    end

    // R6: a settled value does not move unless cleared
    p_settled_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && !clr) |=> $stable(sum));

    // R8: reset leaves an empty, settled accumulator
    p_reset_state_r8: assert property (@(posedge clk)
        !rst_n |=> (sum == '0 && settled));
endmodule

// File: tb/ocsum_ring_acc_tb_top.sv
module ocsum_ring_acc_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        add = 1'b0;
    logic [31:0] din = '0;
    logic [31:0] sum;
    logic        settled;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    ocsum_ring_acc dut_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .add(add),
        .din(din), .sum(sum), .settled(settled)
    );

    localparam int NV = 8;
    localparam logic [31:0] TBL_A [NV] = '{32'h00010002, 32'hFFFF0001, 32'h80008000,
        32'h12345678, 32'hFFFFFFFF, 32'h00000000, 32'h0000FFFF, 32'hFFFF0000};
    localparam logic [31:0] TBL_B [NV] = '{32'h00030004, 32'h0001FFFF, 32'h80008000,
        32'h9ABCDEF0, 32'hFFFFFFFF, 32'h00000000, 32'h00000001, 32'h00000000};
    localparam logic [31:0] TBL_E [NV] = '{32'h00040006, 32'h00010001, 32'h00010001,
        32'hACF03569, 32'hFFFFFFFF, 32'h00000000, 32'h00000001, 32'hFFFF0000};

    function automatic logic [15:0] oc16(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[15:0] + {15'd0, s[16]};
    endfunction

    function automatic logic [31:0] oc32(input logic [31:0] a, input logic [31:0] b);
        return {oc16(a[31:16], b[31:16]), oc16(a[15:0], b[15:0])};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic send(input logic [31:0] w);
        add = 1'b1; din = w;
        step();
        add = 1'b0;
    endtask

    task automatic do_clear();
        clr = 1'b1;
        step();
        clr = 1'b0;
    endtask

    task automatic drain(output int k);
        k = 0;
        while (!settled && k < 20) begin
            step();
            k++;
        end
    endtask

    initial begin
        int k;
        logic [31:0] acc;
        logic [31:0] hold;
        step(); step();
        rst_n = 1'b1;
        step();
        chk("R8 reset sum", sum, 32'h0);
        chk("R8 reset settled", {31'd0, settled}, 32'd1);

        // table of word pairs, streamed back to back
        for (int v = 0; v < NV; v++) begin
            do_clear();
            add = 1'b1; din = TBL_A[v];
            step();
            din = TBL_B[v];
            step();
            add = 1'b0;
            drain(k);
            chk("R2 table vs hand value", sum, TBL_E[v]);
            chk("R1 table vs model", sum, oc32(oc32(32'h0, TBL_A[v]), TBL_B[v]));
        end

        // R9 latency: no change at capture edge, change at next edge
        do_clear();
        send(32'h00050007);
        chk("R9 unchanged after capture edge", sum, 32'h0);
        step();
        chk("R9 updated one edge later", sum, 32'h00050007);

        // R3 / R5: push a carry around the low ring
        do_clear();
        add = 1'b1; din = 32'h0000FFFF;
        step();
        din = 32'h00000001;
        step();
        add = 1'b0;
        step();
        chk("R3 low half after wrap add", {16'h0, sum[15:0]}, 32'h0000FFF8);
        chk("R3 not settled while carry held", {31'd0, settled}, 32'd0);
        drain(k);
        chk("R5 settle clocks", k, 32'd6);
        chk("R5 final wrapped value", sum, 32'h00000001);

        // R4 / R6: add low, data ignored, value holds
        hold = sum;
        din = 32'hDEADBEEF;
        for (int i = 0; i < 5; i++) begin
            step();
            chk("R4 data ignored with add low", sum, hold);
        end
        chk("R6 settled while idle", {31'd0, settled}, 32'd1);

        // R7: clear wins over add in the same cycle
        clr = 1'b1; add = 1'b1; din = 32'h11112222;
        step();
        clr = 1'b0; add = 1'b0;
        repeat (9) step();
        chk("R7 clear beats add", sum, 32'h0);

        // R7: clear also empties a captured word
        send(32'h33334444);
        do_clear();
        repeat (9) step();
        chk("R7 captured word discarded", sum, 32'h0);

        // R2 / R4 / R9: 64-word stream, every third strobe low
        do_clear();
        acc = '0;
        for (int i = 0; i < 64; i++) begin
            din = (i * 32'h9E3779B1) ^ {i[15:0], ~i[15:0]};
            add = (i % 3 != 0);
            if (add) acc = oc32(acc, din);
            step();
        end
        add = 1'b0;
        drain(k);
        chk("R5 stream drained in bound", {31'd0, (k <= 8)}, 32'd1);
        chk("R2 stream vs model", sum, acc);

        // R8: reset mid-run
        send(32'hABCD1234);
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        step();
        chk("R8 reset clears sum", sum, 32'h0);
        chk("R8 reset settled", {31'd0, settled}, 32'd1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule